// File: doc/BRIEF.md
# Split-Way Last-Level Cache Controller with Dirty-Victim Hand-Off

This block is the tag-side controller of a last-level cache whose eight physical ways are divided into two groups. Five ways form an ordinary set-associative store with least-recently-used replacement. The other three hold dirty blocks that were pushed out of that store, so that a later write can still merge on chip instead of going to slow main memory. The controller keeps tags, valid bits and dirty bits for the five ordinary ways only. It reaches the three dirty ways through a narrow side interface with three parts: a same-cycle lookup, a removal strobe and an insertion handshake. How the dirty ways place and age their blocks is decided elsewhere.

A request is an address with a write flag. It is taken when `req_valid` and `req_ready` are both high. The ordinary ways and the dirty-way lookup are checked in the same cycle, and one cycle later the controller reports whether the block was found and where. A miss in both groups starts a fill request to the next level and places the block in the ordinary ways at once. A block found in the dirty ways is reported first. In the cycle after that, it is removed from the dirty ways and installed in the ordinary ways as a new block that is still dirty. When a new block pushes out a clean block, the old block is simply dropped. When it pushes out a dirty block, that block is offered to the dirty ways instead of being written back.

Top module: `llcsplit_ctrl`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and `rsp_valid`, `fill_valid`, `dp_ins_valid` and `dp_remove` are 0. Every ordinary way starts invalid, so the first access to any set is a miss.
- R2: A request that hits an ordinary way gives, in the cycle after it is taken, a single-cycle `rsp_valid` with `rsp_hit`=1, `rsp_loc`=2'b01 and `rsp_way` set to that way's number (0 to 4).
- R3: Replacement works within the set chosen by the line address bits [SET_BITS-1:0]. The lowest-numbered invalid way is used first. When all five ways are valid, the least recently used way is chosen. Every hit or allocation makes its way the most recently used.
- R4: A request that misses both groups gives `rsp_hit`=0, `rsp_loc`=2'b00 and `rsp_way` set to the allocated way. In the same cycle, `fill_valid` pulses for one cycle with `fill_line` equal to request address bits [ADDR_W-1:6], since lines are 64 bytes.
- R5: A write hit marks the block dirty. A write miss allocates the block as dirty. A read miss allocates the block as clean.
- R6: A clean block pushed out of the ordinary ways is discarded: `dp_ins_valid` stays 0.
- R7: A dirty block pushed out of the ordinary ways appears as `dp_ins_valid`=1 with its line address on `dp_ins_line`. Both are held steady until `dp_ins_ready` is seen, and `req_ready` stays 0 for that whole time.
- R8: A request that misses the ordinary ways while `dp_lookup_hit` is 1 gets `rsp_hit`=1 and `rsp_loc`=2'b10 with no fill request. In that same response cycle, `dp_remove` pulses with the line on `dp_remove_line` and `req_ready` is 0. At the end of that cycle the block is allocated in the ordinary ways, after which it hits there.
- R9: A block moved in from the dirty ways keeps its dirty status. If it is later pushed out of the ordinary ways without ever being written, it is still handed to the dirty ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| rsp_valid | output | 1 | Lookup result present (one cycle) |
| rsp_hit | output | 1 | Block found in either group |
| rsp_loc | output | 2 | 00 miss, 01 ordinary ways, 10 dirty ways |
| rsp_way | output | WAY_W | Ordinary way that hit or was allocated |
| fill_valid | output | 1 | Fill request to the next level (one cycle) |
| fill_line | output | LINE_W | Line address to fetch |
| dp_lookup_line | output | LINE_W | Line address being looked up in the dirty ways |
| dp_lookup_hit | input | 1 | Dirty ways hold that line (same cycle) |
| dp_remove | output | 1 | Remove a line from the dirty ways |
| dp_remove_line | output | LINE_W | Line to remove |
| dp_ins_valid | output | 1 | Dirty victim offered to the dirty ways |
| dp_ins_ready | input | 1 | Dirty ways accept the victim |
| dp_ins_line | output | LINE_W | Line address of the dirty victim |

## Verification
Two events can land on the same cycle here. One is a dirty victim that the dirty ways have not yet taken. The other is a new request waiting at the input. The bench causes a dirty eviction and then holds `dp_ins_ready` low while a further request is held on the inputs. For several cycles it checks that `req_ready` stays low, that no response appears, and that the victim line does not change. Once the hand-off completes, it checks that the held request is taken and answered with the correct way. The dirty-way hit, where the response and the removal strobe share one cycle, is judged the same way. The bench then confirms that the promoted block hits in the ordinary ways and is later pushed out as dirty.

// File: rtl/llcsplit_pkg.sv
package llcsplit_pkg;
   localparam int unsigned LINE_BYTES = 64;
   localparam int unsigned OFF_BITS   = $clog2(LINE_BYTES);

   typedef enum logic [1:0] {
      LOC_MISS  = 2'b00,
      LOC_NORM  = 2'b01,
      LOC_DIRTY = 2'b10
   } hit_loc_e;
endpackage

// File: rtl/llcsplit_ways.sv
module llcsplit_ways #(
   parameter int SET_BITS = 4,
   parameter int TAG_W    = 12,
   parameter int WAYS     = 5,
   parameter int WAY_W    = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SET_BITS-1:0]    rd_set,
   input  logic [TAG_W-1:0]       rd_tag,
   output logic [WAYS-1:0]        hit_vec,
   output logic [WAYS-1:0]        valid_vec,
   output logic [WAYS-1:0]        dirty_vec,
   output logic [WAYS*TAG_W-1:0]  tag_flat,
   input  logic                   wr_en,
   input  logic [SET_BITS-1:0]    wr_set,
   input  logic [WAY_W-1:0]       wr_way,
   input  logic [TAG_W-1:0]       wr_tag,
   input  logic                   wr_dirty
);
   localparam int SETS = 1 << SET_BITS;

   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   logic [WAYS-1:0]  vld_q   [SETS];
   logic [WAYS-1:0]  dirty_q [SETS];

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign tag_flat[w*TAG_W +: TAG_W] = tag_q[rd_set][w];
      assign valid_vec[w] = vld_q[rd_set][w];
      assign dirty_vec[w] = dirty_q[rd_set][w];
      assign hit_vec[w]   = vld_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s]   <= '0;
            dirty_q[s] <= '0;
         end
      end else if (wr_en) begin
         vld_q[wr_set][wr_way]   <= 1'b1;
         dirty_q[wr_set][wr_way] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
   end

   // R2: a tag never lives in two ordinary ways of one set
   p_hit_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
endmodule

// File: rtl/llcsplit_lru.sv
module llcsplit_lru #(
   parameter int SET_BITS = 4,
   parameter int WAYS     = 5,
   parameter int WAY_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SET_BITS-1:0] rd_set,
   input  logic [WAYS-1:0]     valid_vec,
   output logic [WAY_W-1:0]    victim_way,
   input  logic                touch_en,
   input  logic [SET_BITS-1:0] touch_set,
   input  logic [WAY_W-1:0]    touch_way
);
   localparam int SETS  = 1 << SET_BITS;
   localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   logic [AGE_W-1:0] age_q [SETS][WAYS];
   logic [WAYS-1:0]  mru_vec;

   always_comb begin
      logic found;
      found      = 1'b0;
      victim_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!found && !valid_vec[w]) begin
            victim_way = WAY_W'(w);
            found      = 1'b1;
         end
      end
      if (!found) begin
         for (int w = 0; w < WAYS; w++) begin
            if (age_q[rd_set][w] == AGE_W'(WAYS-1)) victim_way = WAY_W'(w);
         end
      end
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_mru
      assign mru_vec[w] = (age_q[rd_set][w] == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= AGE_W'(w);
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
               age_q[touch_set][w] <= '0;
            else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
               age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
         end
      end
   end

   // R3: exactly one most-recent way per set at all times
   p_single_mru_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mru_vec) == 1);
endmodule

// File: rtl/llcsplit_ctrl.sv
module llcsplit_ctrl
   import llcsplit_pkg::*;
#(
   parameter int SET_BITS   = 4,
   parameter int TAG_W      = 12,
   parameter int TOTAL_WAYS = 8,
   parameter int DIRTY_WAYS = 3,
   localparam int NORM_WAYS = TOTAL_WAYS - DIRTY_WAYS,
   localparam int WAY_W     = (NORM_WAYS > 1) ? $clog2(NORM_WAYS) : 1,
   localparam int LINE_W    = TAG_W + SET_BITS,
   localparam int ADDR_W    = LINE_W + OFF_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [1:0]        rsp_loc,
   output logic [WAY_W-1:0]  rsp_way,
   output logic              fill_valid,
   output logic [LINE_W-1:0] fill_line,
   output logic [LINE_W-1:0] dp_lookup_line,
   input  logic              dp_lookup_hit,
   output logic              dp_remove,
   output logic [LINE_W-1:0] dp_remove_line,
   output logic              dp_ins_valid,
   input  logic              dp_ins_ready,
   output logic [LINE_W-1:0] dp_ins_line
);
   if (DIRTY_WAYS < 1 || DIRTY_WAYS >= TOTAL_WAYS - 1) begin : g_bad_split
      $error("dirty-way count must leave at least two ordinary ways");
   end
   if (SET_BITS < 1 || TAG_W < 1) begin : g_bad_geom
      $error("set and tag widths must be positive");
   end

   logic [LINE_W-1:0]          req_line;
   logic                       promo_q;
   logic [LINE_W-1:0]          promo_line_q;
   logic [LINE_W-1:0]          cur_line;
   logic [SET_BITS-1:0]        cur_set;
   logic [TAG_W-1:0]           cur_tag;
   logic [NORM_WAYS-1:0]       hit_vec, valid_vec, dirty_vec;
   logic [NORM_WAYS*TAG_W-1:0] tag_flat;
   logic [WAY_W-1:0]           victim, hit_way, use_way;
   logic                       norm_hit, accept, alloc, evict_dirty;
   logic                       upd_en;
   logic                       rsp_valid_q, rsp_hit_q, fill_q, ins_q;
   hit_loc_e                   loc_q;
   logic [WAY_W-1:0]           way_q;
   logic [LINE_W-1:0]          fill_line_q, ins_line_q;
   logic                       unused_off;

   assign unused_off = ^req_addr[OFF_BITS-1:0];
   assign req_line   = req_addr[ADDR_W-1:OFF_BITS];
   assign cur_line   = promo_q ? promo_line_q : req_line;
   assign cur_set    = cur_line[SET_BITS-1:0];
   assign cur_tag    = cur_line[LINE_W-1:SET_BITS];

   llcsplit_ways #(.SET_BITS(SET_BITS), .TAG_W(TAG_W), .WAYS(NORM_WAYS), .WAY_W(WAY_W)) u_ways (
      .clk, .rst_n,
      .rd_set   (cur_set),
      .rd_tag   (cur_tag),
      .hit_vec, .valid_vec, .dirty_vec, .tag_flat,
      .wr_en    (upd_en && (alloc || req_write)),
      .wr_set   (cur_set),
      .wr_way   (use_way),
      .wr_tag   (cur_tag),
      .wr_dirty (promo_q || req_write)
   );

   llcsplit_lru #(.SET_BITS(SET_BITS), .WAYS(NORM_WAYS), .WAY_W(WAY_W)) u_lru (
      .clk, .rst_n,
      .rd_set     (cur_set),
      .valid_vec,
      .victim_way (victim),
      .touch_en   (upd_en),
      .touch_set  (cur_set),
      .touch_way  (use_way)
   );

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < NORM_WAYS; w++)
         if (hit_vec[w]) hit_way = WAY_W'(w);
   end

   assign norm_hit    = |hit_vec;
   assign req_ready   = !promo_q && !ins_q;
   assign accept      = req_valid && req_ready;
   assign alloc       = promo_q || (accept && !norm_hit && !dp_lookup_hit);
   assign upd_en      = alloc || (accept && norm_hit);
   assign use_way     = alloc ? victim : hit_way;
   assign evict_dirty = alloc && valid_vec[victim] && dirty_vec[victim];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_hit_q   <= 1'b0;
         loc_q       <= LOC_MISS;
         way_q       <= '0;
         fill_q      <= 1'b0;
         fill_line_q <= '0;
         promo_q     <= 1'b0;
         promo_line_q <= '0;
         ins_q       <= 1'b0;
         ins_line_q  <= '0;
      end else begin
         rsp_valid_q <= accept;
         fill_q      <= accept && !norm_hit && !dp_lookup_hit;
         promo_q     <= accept && !norm_hit && dp_lookup_hit;
         if (accept) begin
            rsp_hit_q    <= norm_hit || dp_lookup_hit;
            loc_q        <= norm_hit ? LOC_NORM : (dp_lookup_hit ? LOC_DIRTY : LOC_MISS);
            way_q        <= norm_hit ? hit_way : (dp_lookup_hit ? '0 : victim);
            fill_line_q  <= req_line;
            promo_line_q <= req_line;
         end
         if (evict_dirty) begin
            ins_q      <= 1'b1;
            ins_line_q <= {tag_flat[int'(victim)*TAG_W +: TAG_W], cur_set};
         end else if (dp_ins_ready) begin
            ins_q <= 1'b0;
         end
      end
   end

   assign rsp_valid      = rsp_valid_q;
   assign rsp_hit        = rsp_hit_q;
   assign rsp_loc        = loc_q;
   assign rsp_way        = way_q;
   assign fill_valid     = fill_q;
   assign fill_line      = fill_line_q;
   assign dp_lookup_line = req_line;
   assign dp_remove      = promo_q;
   assign dp_remove_line = promo_line_q;
   assign dp_ins_valid   = ins_q;
   assign dp_ins_line    = ins_line_q;

   // R2: a response follows exactly one accepted request
   p_rsp_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && req_ready));
   // R4: a fill request only accompanies a miss response, carrying the taken line
   p_fill_on_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> (rsp_valid && !rsp_hit && rsp_loc == LOC_MISS));
   p_fill_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> fill_line == $past(req_addr[ADDR_W-1:OFF_BITS]));
   // R7: a waiting victim blocks requests and holds its line
   p_stall_on_victim_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dp_ins_valid |-> !req_ready);
   p_victim_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_ins_valid && !dp_ins_ready) |=> (dp_ins_valid && $stable(dp_ins_line)));
   // R8: removal only in the dirty-hit response cycle
   p_remove_with_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dp_remove |-> (rsp_valid && rsp_loc == LOC_DIRTY && !req_ready && !fill_valid));
endmodule

// File: tb/llcsplit_ctrl_test.sv
module llcsplit_ctrl_test;
   localparam int SET_BITS = 4;
   localparam int TAG_W    = 12;
   localparam int LINE_W   = TAG_W + SET_BITS;
   localparam int ADDR_W   = LINE_W + 6;
   localparam int WAY_W    = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_write = 1'b0;
   logic              rsp_valid, rsp_hit;
   logic [1:0]        rsp_loc;
   logic [WAY_W-1:0]  rsp_way;
   logic              fill_valid;
   logic [LINE_W-1:0] fill_line, dp_lookup_line, dp_remove_line, dp_ins_line;
   logic              dp_lookup_hit;
   logic              dp_remove, dp_ins_valid;
   logic              dp_hit_r = 1'b0;
   logic              ins_rdy = 1'b1;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   always #4 clk = ~clk;

   assign dp_lookup_hit = dp_hit_r;

   llcsplit_ctrl #(.SET_BITS(SET_BITS), .TAG_W(TAG_W)) uut (
      .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_write,
      .rsp_valid, .rsp_hit, .rsp_loc, .rsp_way, .fill_valid, .fill_line,
      .dp_lookup_line, .dp_lookup_hit, .dp_remove, .dp_remove_line,
      .dp_ins_valid, .dp_ins_ready(ins_rdy), .dp_ins_line
   );

   // model of the dirty ways: a plain list of lines
   logic [LINE_W-1:0] dpm_line [16];
   bit                dpm_v    [16];

   function automatic bit dpm_has(input logic [LINE_W-1:0] l);
      for (int i = 0; i < 16; i++) if (dpm_v[i] && dpm_line[i] == l) return 1'b1;
      return 1'b0;
   endfunction

   task automatic dpm_add(input logic [LINE_W-1:0] l);
      for (int i = 0; i < 16; i++) if (!dpm_v[i]) begin
         dpm_v[i] = 1'b1; dpm_line[i] = l; return;
      end
   endtask

   task automatic dpm_del(input logic [LINE_W-1:0] l);
      for (int i = 0; i < 16; i++) if (dpm_v[i] && dpm_line[i] == l) dpm_v[i] = 1'b0;
   endtask

   function automatic logic [LINE_W-1:0] ln(input int tg, input int st);
      return {TAG_W'(tg), SET_BITS'(st)};
   endfunction

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic cyc();
      if (dp_ins_valid && ins_rdy) dpm_add(dp_ins_line);
      if (dp_remove) dpm_del(dp_remove_line);
      @(posedge clk);
      @(negedge clk);
      dp_hit_r = dpm_has(req_addr[ADDR_W-1:6]);
   endtask

   // captured response
   logic c_valid, c_hit, c_fill, c_ins, c_rem, c_rdy;
   logic [1:0] c_loc;
   logic [WAY_W-1:0] c_way;
   logic [LINE_W-1:0] c_fline, c_iline, c_rline;

   task automatic access(input int tg, input int st, input bit wr);
      req_valid = 1'b1;
      req_addr  = {ln(tg, st), 6'h2a};
      req_write = wr;
      dp_hit_r  = dpm_has(ln(tg, st));
      while (!req_ready) cyc();
      cyc();
      c_valid = rsp_valid;  c_hit = rsp_hit;  c_loc = rsp_loc;  c_way = rsp_way;
      c_fill  = fill_valid; c_fline = fill_line;
      c_ins   = dp_ins_valid; c_iline = dp_ins_line;
      c_rem   = dp_remove;  c_rline = dp_remove_line;
      c_rdy   = req_ready;
      req_valid = 1'b0;
      req_write = 1'b0;
   endtask

   task automatic exp_miss(input string tagname, input int way, input int tg, input int st);
      check({tagname, " R4 rsp_valid"}, c_valid, 1);
      check({tagname, " R4 hit"}, c_hit, 0);
      check({tagname, " R4 loc"}, c_loc, 2'b00);
      check({tagname, " R3 way"}, c_way, way);
      check({tagname, " R4 fill_valid"}, c_fill, 1);
      check({tagname, " R4 fill_line"}, c_fline, ln(tg, st));
   endtask

   task automatic exp_norm_hit(input string tagname, input int way);
      check({tagname, " R2 rsp_valid"}, c_valid, 1);
      check({tagname, " R2 hit"}, c_hit, 1);
      check({tagname, " R2 loc"}, c_loc, 2'b01);
      check({tagname, " R2 way"}, c_way, way);
      check({tagname, " R2 no fill"}, c_fill, 0);
   endtask

   task automatic t_reset();
      check("R1 ready in reset", req_ready, 1);
      check("R1 rsp_valid in reset", rsp_valid, 0);
      check("R1 fill_valid in reset", fill_valid, 0);
      check("R1 ins_valid in reset", dp_ins_valid, 0);
      check("R1 remove in reset", dp_remove, 0);
      rst_n = 1'b1;
      cyc();
      check("R1 ready after reset", req_ready, 1);
      check("R1 rsp_valid after reset", rsp_valid, 0);
   endtask

   task automatic t_cold_fill();
      for (int t = 1; t <= 5; t++) begin
         access(t, 1, 1'b0);
         exp_miss("cold R1", t - 1, t, 1);
         check("cold R6 no hand-off", c_ins, 0);
      end
   endtask

   task automatic t_hit_and_lru();
      access(3, 1, 1'b0); exp_norm_hit("hit3", 2);
      access(6, 1, 1'b0); exp_miss("lru6", 0, 6, 1);
      check("lru6 R6 clean victim dropped", c_ins, 0);
      access(2, 1, 1'b0); exp_norm_hit("hit2", 1);
      access(7, 1, 1'b0); exp_miss("lru7 R3", 3, 7, 1);
   endtask

   task automatic t_write_dirty();
      access(3, 1, 1'b1); exp_norm_hit("whit3 R5", 2);
      access(8, 1, 1'b1); exp_miss("wmiss8 R5", 4, 8, 1);
      check("wmiss8 R6", c_ins, 0);
      access(9, 1, 1'b0);  exp_miss("m9", 0, 9, 1);
      check("m9 R6 clean", c_ins, 0);
      access(10, 1, 1'b0); exp_miss("m10", 1, 10, 1);
      check("m10 R6 clean", c_ins, 0);
      access(11, 1, 1'b0); exp_miss("m11", 3, 11, 1);
      check("m11 R6 clean", c_ins, 0);
      access(12, 1, 1'b0); exp_miss("m12", 2, 12, 1);
      check("m12 R5 dirty victim offered", c_ins, 1);
      check("m12 R7 victim line", c_iline, ln(3, 1));
      check("m12 R7 ready low", c_rdy, 0);
      cyc();
      check("R7 ready back after hand-off", req_ready, 1);
      check("R7 ins cleared", dp_ins_valid, 0);
   endtask

   task automatic t_stalled_handoff();
      ins_rdy = 1'b0;
      access(13, 1, 1'b0); exp_miss("m13", 4, 13, 1);
      check("m13 R5 write-miss block is dirty", c_ins, 1);
      check("m13 R7 line", c_iline, ln(8, 1));
      req_valid = 1'b1;
      req_addr  = {ln(9, 1), 6'h00};
      dp_hit_r  = dpm_has(ln(9, 1));
      for (int i = 0; i < 3; i++) begin
         cyc();
         check("stall R7 ready low", req_ready, 0);
         check("stall R7 no response", rsp_valid, 0);
         check("stall R7 victim held", dp_ins_valid, 1);
         check("stall R7 line held", dp_ins_line, ln(8, 1));
      end
      ins_rdy = 1'b1;
      access(9, 1, 1'b0); exp_norm_hit("after stall R7", 0);
   endtask

   task automatic t_dirty_hit();
      access(3, 1, 1'b0);
      check("dhit R8 rsp_valid", c_valid, 1);
      check("dhit R8 hit", c_hit, 1);
      check("dhit R8 loc", c_loc, 2'b10);
      check("dhit R8 no fill", c_fill, 0);
      check("dhit R8 remove", c_rem, 1);
      check("dhit R8 remove line", c_rline, ln(3, 1));
      check("dhit R8 ready low", c_rdy, 0);
      access(3, 1, 1'b0); exp_norm_hit("promoted R8", 1);
      check("promoted R6 clean victim", c_ins, 0);
   endtask

   task automatic t_promoted_dirty();
      access(14, 1, 1'b0); exp_miss("p14", 3, 14, 1);
      access(15, 1, 1'b0); exp_miss("p15", 2, 15, 1);
      access(16, 1, 1'b0); exp_miss("p16", 4, 16, 1);
      access(17, 1, 1'b0); exp_miss("p17", 0, 17, 1);
      check("p17 R6 clean", c_ins, 0);
      access(18, 1, 1'b0); exp_miss("p18", 1, 18, 1);
      check("p18 R9 promoted block still dirty", c_ins, 1);
      check("p18 R9 line", c_iline, ln(3, 1));
   endtask

   task automatic t_other_set();
      access(3, 2, 1'b0); exp_miss("set2 R3", 0, 3, 2);
      check("set2 R6", c_ins, 0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) dpm_v[i] = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      t_cold_fill();
      t_hit_and_lru();
      t_write_dirty();
      t_stalled_handoff();
      t_dirty_hit();
      t_promoted_dirty();
      t_other_set();
      repeat (3) cyc();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1;
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
         $finish;
      end
   end
endmodule